// File: doc/BRIEF.md
# Write-Back Translation Buffer with Page Table Walker

This block translates 32-bit virtual addresses into 29-bit physical addresses using 1 MiB pages. A 32-slot, fully associative translation buffer is searched first. On a hit the physical page number is joined to the untouched 20-bit offset, and the result is returned one cycle after the request is accepted. On a miss a single-level walker reads one 32-bit page table word from memory, at the word address formed by the base register plus the virtual page number. It installs the mapping and then responds.

The buffer is write-back. Each slot keeps its own dirty and referenced state. A write that is allowed marks the slot dirty. When a dirty slot is chosen for replacement, its mapping is first written back into its page table word, and only then is the slot reused. A context switch invalidates every slot: either the flush input is pulsed or the base register takes a new value. Only one translation is in progress at a time.

Top module: `tlb_walker_top`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0.
- R2: A request whose page is held in a valid slot is answered in the cycle right after acceptance. The answer has `rsp_pa` = {slot PPN, VA[19:0]}, fault code 0 and no memory transaction.
- R3: On a miss, exactly one memory read is made, at word address `ptbr` + VA[31:20]. The page table word layout is: bit 31 valid, bit 30 dirty, bit 29 write allowed, bit 28 read allowed, bit 27 referenced, bits 8:0 PPN, and bits 26:9 reserved (zero). A usable word is installed and the access is answered using the PPN of that word.
- R4: If the page table word read on a miss has bit 31 clear, or any reserved bit set, the response is fault code 1 with PA 0. Nothing is installed, so the next access to that page misses again.
- R5: A write needs bit 29 and a read needs bit 28. When the needed right is missing, the response is fault code 2 with PA 0. On a hit this leaves the slot, its dirty state and the replacement order unchanged. On a miss the mapping is still installed, but it is not marked dirty by the access.
- R6: An allowed write marks its slot dirty, and so does a page table word whose bit 30 is set. When a dirty slot is replaced, a memory write of {1, 1, write right, read right, 1, zeros, PPN} goes to `ptbr` + that slot's VPN. This write comes after the page table read and before the fill, giving two memory transactions for that miss.
- R7: On a fill, the lowest-numbered invalid slot is used first. If no slot is invalid, the least recently used slot is replaced. Allowed hits and all fills make their slot the most recently used.
- R8: Pulsing `flush`, or changing `ptbr`, invalidates every slot and restores the replacement order to the reset order. `req_ready` is 0 in that cycle, and a later access to any page misses.
- R9: `req_ready` is 0 from acceptance of a miss until its response. A memory request holds its address and direction until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_pa | output | 29 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 page fault, 2 protection fault |
| ptbr | input | 29 | Page table base word address |
| flush | input | 1 | Invalidate all slots |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write-back, 0 = page table read |
| mem_addr | output | 29 | Page table word address |
| mem_wdata | output | 32 | Page table word written back |
| mem_ack | input | 1 | Memory completes the transaction this edge |
| mem_rdata | input | 32 | Page table word read, valid with `mem_ack` |

## Verification
The properties assume that `flush` and `ptbr` only move while no translation is outstanding, that the request fields stay steady while `req_valid` waits for acceptance, and that memory eventually acknowledges. The stimulus respects all three. Context switches and base changes are issued only after a response has arrived. The request is held until `req_ready` is seen. The model memory acknowledges on a random three cycles out of four. Page numbers come from a pool larger than the buffer, so evictions of dirty and clean slots occur alongside faults of both kinds.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;
    localparam int VA_W   = 32;
    localparam int OFF_W  = 20;
    localparam int PA_W   = 29;
    localparam int PTE_W  = 32;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PPN_W  = PA_W - OFF_W;

    // page table word fields
    localparam int PTE_V   = 31;
    localparam int PTE_D   = 30;
    localparam int PTE_WR  = 29;
    localparam int PTE_RD  = 28;
    localparam int PTE_REF = 27;
    localparam int RSV_HI  = PTE_REF - 1;
    localparam int RSV_LO  = PPN_W;

    localparam logic [1:0] FLT_NONE = 2'd0;
    localparam logic [1:0] FLT_PAGE = 2'd1;
    localparam logic [1:0] FLT_PROT = 2'd2;

    typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_WB, ST_FILL} walk_st_e;

    typedef struct packed {
        logic              valid;
        logic              refd;
        logic              dirty;
        logic              wr_ok;
        logic              rd_ok;
        logic [VPN_W-1:0]  tag;
        logic [PPN_W-1:0]  ppn;
    } slot_t;
endpackage

// File: rtl/tlbw_cam.sv
module tlbw_cam
    import tlbw_pkg::*;
#(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             hit,
    output logic [IW-1:0]    hit_idx,
    output slot_t            hit_slot,
    input  logic [IW-1:0]    sel_idx,
    output slot_t            sel_slot,
    output logic [N-1:0]     valid_vec,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  slot_t            wr_slot
);
    slot_t        slots_q [N];
    logic [N-1:0] match;

    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slots_q[g] <= '0;
            end else if (clr_all) begin
                slots_q[g].valid <= 1'b0;
            end else if (wr_en && wr_idx == IW'(g)) begin
                slots_q[g] <= wr_slot;
            end
        end
        assign match[g]     = slots_q[g].valid && slots_q[g].tag == lk_vpn;
        assign valid_vec[g] = slots_q[g].valid;
    end

    always_comb begin
        hit     = |match;
        hit_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) hit_idx = IW'(i);
        end
        hit_slot = slots_q[hit_idx];
        sel_slot = slots_q[sel_idx];
    end
endmodule

// File: rtl/tlbw_lru.sv
module tlbw_lru #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reorder,
    input  logic          touch,
    input  logic [IW-1:0] touch_idx,
    output logic [IW-1:0] lru_idx
);
    // rank 0 = most recent, rank N-1 = next to be replaced
    logic [IW-1:0] rank_q [N];
    logic [IW-1:0] touched_rank;

    assign touched_rank = rank_q[touch_idx];

    for (genvar g = 0; g < N; g++) begin : g_rank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rank_q[g] <= IW'(g);
            end else if (reorder) begin
                rank_q[g] <= IW'(g);
            end else if (touch) begin
                if (touch_idx == IW'(g)) begin
                    rank_q[g] <= '0;
                end else if (rank_q[g] < touched_rank) begin
                    rank_q[g] <= rank_q[g] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        lru_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (rank_q[i] == IW'(N - 1)) lru_idx = IW'(i);
        end
    end
endmodule

// File: rtl/tlb_walker_top.sv
module tlb_walker_top
    import tlbw_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [1:0]        rsp_fault,
    input  logic [PA_W-1:0]   ptbr,
    input  logic              flush,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [PTE_W-1:0]  mem_wdata,
    input  logic              mem_ack,
    input  logic [PTE_W-1:0]  mem_rdata
);
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        walk_st_e          st;
        logic [VPN_W-1:0]  vpn;
        logic [OFF_W-1:0]  off;
        logic              wr;
        logic              pte_d;
        logic              pte_w;
        logic              pte_r;
        logic [PPN_W-1:0]  pte_ppn;
        logic [IDX_W-1:0]  vict;
        logic              rsp_v;
        logic [PA_W-1:0]   rsp_pa;
        logic [1:0]        rsp_f;
        logic [PA_W-1:0]   base;
    } regs_t;

    regs_t q, n;

    logic               flush_now;
    logic [VPN_W-1:0]   lk_vpn;
    logic               hit;
    logic [IDX_W-1:0]   hit_idx;
    slot_t              hit_slot;
    logic [IDX_W-1:0]   sel_idx;
    slot_t              sel_slot;
    logic [ENTRIES-1:0] valid_vec;
    logic               cam_we;
    logic [IDX_W-1:0]   cam_widx;
    slot_t              cam_wslot;
    logic               lru_touch;
    logic [IDX_W-1:0]   lru_tidx;
    logic [IDX_W-1:0]   lru_idx;
    logic [IDX_W-1:0]   victim;
    logic               allowed;
    logic               pte_ok;

    tlbw_cam #(.N(ENTRIES), .IW(IDX_W)) cam_i (
        .clk(clk), .rst_n(rst_n), .clr_all(flush_now), .lk_vpn(lk_vpn),
        .hit(hit), .hit_idx(hit_idx), .hit_slot(hit_slot),
        .sel_idx(sel_idx), .sel_slot(sel_slot), .valid_vec(valid_vec),
        .wr_en(cam_we), .wr_idx(cam_widx), .wr_slot(cam_wslot)
    );

    tlbw_lru #(.N(ENTRIES), .IW(IDX_W)) lru_i (
        .clk(clk), .rst_n(rst_n), .reorder(flush_now),
        .touch(lru_touch), .touch_idx(lru_tidx), .lru_idx(lru_idx)
    );

    always_comb begin
        n         = q;
        n.rsp_v   = 1'b0;
        n.rsp_f   = FLT_NONE;
        n.rsp_pa  = '0;
        n.base    = ptbr;
        flush_now = flush || (ptbr != q.base);
        req_ready = (q.st == ST_IDLE) && !flush_now;
        lk_vpn    = req_va[VA_W-1:OFF_W];
        allowed   = 1'b0;
        cam_we    = 1'b0;
        cam_widx  = hit_idx;
        cam_wslot = hit_slot;
        lru_touch = 1'b0;
        lru_tidx  = hit_idx;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.base + PA_W'(q.vpn);
        mem_wdata = '0;
        pte_ok    = mem_rdata[PTE_V] && (mem_rdata[RSV_HI:RSV_LO] == '0);

        victim = lru_idx;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) victim = IDX_W'(i);
        end
        sel_idx = (q.st == ST_WALK) ? victim : q.vict;

        case (q.st)
            ST_IDLE: begin
                if (req_valid && req_ready) begin
                    if (hit) begin
                        allowed = req_write ? hit_slot.wr_ok : hit_slot.rd_ok;
                        n.rsp_v = 1'b1;
                        if (allowed) begin
                            cam_we          = 1'b1;
                            cam_wslot.refd  = 1'b1;
                            cam_wslot.dirty = hit_slot.dirty | req_write;
                            lru_touch       = 1'b1;
                            n.rsp_pa        = {hit_slot.ppn, req_va[OFF_W-1:0]};
                        end else begin
                            n.rsp_f = FLT_PROT;
                        end
                    end else begin
                        n.st  = ST_WALK;
                        n.vpn = lk_vpn;
                        n.off = req_va[OFF_W-1:0];
                        n.wr  = req_write;
                    end
                end
            end
            ST_WALK: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    if (!pte_ok) begin
                        n.rsp_v = 1'b1;
                        n.rsp_f = FLT_PAGE;
                        n.st    = ST_IDLE;
                    end else begin
                        n.pte_d   = mem_rdata[PTE_D];
                        n.pte_w   = mem_rdata[PTE_WR];
                        n.pte_r   = mem_rdata[PTE_RD];
                        n.pte_ppn = mem_rdata[PPN_W-1:0];
                        n.vict    = victim;
                        n.st      = (sel_slot.valid && sel_slot.dirty) ? ST_WB : ST_FILL;
                    end
                end
            end
            ST_WB: begin
                mem_req                = 1'b1;
                mem_we                 = 1'b1;
                mem_addr               = q.base + PA_W'(sel_slot.tag);
                mem_wdata[PTE_V]       = 1'b1;
                mem_wdata[PTE_D]       = 1'b1;
                mem_wdata[PTE_WR]      = sel_slot.wr_ok;
                mem_wdata[PTE_RD]      = sel_slot.rd_ok;
                mem_wdata[PTE_REF]     = sel_slot.refd;
                mem_wdata[PPN_W-1:0]   = sel_slot.ppn;
                if (mem_ack) n.st = ST_FILL;
            end
            ST_FILL: begin
                allowed         = q.wr ? q.pte_w : q.pte_r;
                cam_we          = 1'b1;
                cam_widx        = q.vict;
                cam_wslot.valid = 1'b1;
                cam_wslot.refd  = 1'b1;
                cam_wslot.dirty = q.pte_d | (q.wr & allowed);
                cam_wslot.wr_ok = q.pte_w;
                cam_wslot.rd_ok = q.pte_r;
                cam_wslot.tag   = q.vpn;
                cam_wslot.ppn   = q.pte_ppn;
                lru_touch       = 1'b1;
                lru_tidx        = q.vict;
                n.rsp_v         = 1'b1;
                n.rsp_f         = allowed ? FLT_NONE : FLT_PROT;
                n.rsp_pa        = allowed ? {q.pte_ppn, q.off} : '0;
                n.st            = ST_IDLE;
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign rsp_valid = q.rsp_v;
    assign rsp_pa    = q.rsp_pa;
    assign rsp_fault = q.rsp_f;
endmodule

// File: rtl/tlbw_checker.sv
module tlbw_checker
    import tlbw_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             flush,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_ack,
    input logic [PA_W-1:0]  mem_addr,
    input logic [PTE_W-1:0] mem_wdata,
    input logic             rsp_valid,
    input logic [1:0]       rsp_fault,
    input logic [PA_W-1:0]  rsp_pa
);
    assert_ready_low_walk_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_flush_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !req_ready);

    assert_fault_pa_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_pa == '0));   // also R5

    assert_fault_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault != 2'b11));

    assert_wb_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[PTE_V] && mem_wdata[PTE_D] && mem_wdata[PTE_REF]));
endmodule

bind tlb_walker_top tlbw_checker chk_i (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .flush(flush),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa)
);

// File: tb/tlb_walker_top_tb_top.sv
module tlb_walker_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic [28:0] rsp_pa;
    logic [1:0]  rsp_fault;
    logic [28:0] ptbr = '0;
    logic        flush = 1'b0;
    logic        mem_req, mem_we, mem_ack;
    logic [28:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        ack_en = 1'b1;

    always #5 clk = ~clk;

    tlb_walker_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_write(req_write), .rsp_valid(rsp_valid),
        .rsp_pa(rsp_pa), .rsp_fault(rsp_fault), .ptbr(ptbr), .flush(flush),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // memory holding two page tables, at word 0 and word 4096
    logic [31:0] pt_mem [8192];
    logic [31:0] exp_pt [8192];
    int nrd, nwr;

    assign mem_ack   = mem_req & ack_en;
    assign mem_rdata = pt_mem[mem_addr[12:0]];

    always @(negedge clk) ack_en <= ($urandom % 4) != 0;

    always @(posedge clk) begin
        if (mem_req && mem_ack) begin
            if (mem_we) begin
                pt_mem[mem_addr[12:0]] <= mem_wdata;
                nwr = nwr + 1;
            end else begin
                nrd = nrd + 1;
            end
        end
    end

    // reference model of the buffer
    bit        m_v [32];
    bit        m_d [32];
    bit        m_w [32];
    bit        m_r [32];
    bit [11:0] m_tag [32];
    bit [8:0]  m_ppn [32];
    int        m_rank [32];
    int        cur_base = 0;

    int checks = 0, fails = 0;
    bit done = 0;

    function automatic logic [31:0] mk_pte(bit v, bit d, bit w, bit r, bit [8:0] ppn);
        return {v, d, w, r, 1'b0, 18'b0, ppn};
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_flush();
        for (int j = 0; j < 32; j++) begin
            m_v[j] = 0;
            m_rank[j] = j;
        end
    endtask

    task automatic model_touch(int i);
        for (int j = 0; j < 32; j++) if (m_rank[j] < m_rank[i]) m_rank[j]++;
        m_rank[i] = 0;
    endtask

    task automatic model_access(input bit [11:0] vpn, input bit [19:0] off, input bit wr,
                                output bit [28:0] pa, output bit [1:0] f,
                                output int erd, output int ewr);
        int hi = -1;
        bit ok;
        pa = '0; f = 0; erd = 0; ewr = 0;
        for (int j = 0; j < 32; j++) if (m_v[j] && m_tag[j] == vpn) hi = j;
        if (hi >= 0) begin
            ok = wr ? m_w[hi] : m_r[hi];
            if (ok) begin
                m_d[hi] = m_d[hi] | wr;
                model_touch(hi);
                pa = {m_ppn[hi], off};
            end else begin
                f = 2;
            end
        end else begin
            logic [31:0] pte;
            int vi = -1;
            erd = 1;
            pte = exp_pt[cur_base + int'(vpn)];
            if (!pte[31] || pte[26:9] != 0) begin
                f = 1;
            end else begin
                for (int j = 31; j >= 0; j--) if (!m_v[j]) vi = j;
                if (vi < 0) for (int j = 0; j < 32; j++) if (m_rank[j] == 31) vi = j;
                if (m_v[vi] && m_d[vi]) begin
                    exp_pt[cur_base + int'(m_tag[vi])] = {1'b1, 1'b1, m_w[vi], m_r[vi], 1'b1, 18'b0, m_ppn[vi]};
                    ewr = 1;
                end
                ok = wr ? pte[29] : pte[28];
                m_v[vi] = 1; m_tag[vi] = vpn; m_ppn[vi] = pte[8:0];
                m_w[vi] = pte[29]; m_r[vi] = pte[28];
                m_d[vi] = pte[30] | (wr & ok);
                model_touch(vi);
                f = ok ? 2'd0 : 2'd2;
                pa = ok ? {pte[8:0], off} : '0;
            end
        end
    endtask

    task automatic xlate(input bit [11:0] vpn, input bit wr);
        bit [19:0] off = 20'($urandom);
        bit [28:0] e_pa;
        bit [1:0]  e_f;
        int e_rd, e_wr, waits;
        bit rbad;
        string rq;
        model_access(vpn, off, wr, e_pa, e_f, e_rd, e_wr);
        @(negedge clk);
        req_va = {vpn, off}; req_write = wr; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        nrd = 0; nwr = 0;
        @(negedge clk);
        req_valid = 1'b0;
        waits = 0; rbad = 0;
        while (!rsp_valid && waits < 200) begin
            if (req_ready) rbad = 1;
            @(negedge clk);
            waits++;
        end
        rq = (e_f == 1) ? "R4" : (e_f == 2) ? "R5" : (e_wr != 0) ? "R6" : (e_rd != 0) ? "R3" : "R2";
        check(rsp_valid == 1'b1, rq, "response seen", rsp_valid, 1);
        check(rsp_pa == e_pa, rq, "physical address", rsp_pa, e_pa);
        check(rsp_fault == e_f, rq, "fault code", rsp_fault, e_f);
        check(nrd == e_rd, (e_rd != 0) ? "R3" : "R2", "page table reads", nrd, e_rd);
        check(nwr == e_wr, "R6", "write-backs", nwr, e_wr);
        if (e_rd == 0) check(waits == 0, "R2", "hit latency", waits, 0);
        else           check(rbad == 0, "R9", "ready low during walk", rbad, 0);
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        #1;
        check(req_ready == 1'b0, "R8", "ready during flush", req_ready, 0);
        model_flush();
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic set_base(int b);
        @(negedge clk);
        ptbr = 29'(b);
        #1;
        check(req_ready == 1'b0, "R8", "ready during base change", req_ready, 0);
        model_flush();
        cur_base = b;
        @(negedge clk);
    endtask

    task automatic set_pte(int idx, logic [31:0] w);
        pt_mem[idx] = w;
        exp_pt[idx] = w;
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 8192; i++) begin
            logic [31:0] w = mk_pte(($urandom % 8) != 0, $urandom % 2, $urandom % 2,
                                    ($urandom % 4) != 0, 9'($urandom));
            if ($urandom % 25 == 0) w[9] = 1'b1;
            set_pte(i, w);
        end
        set_pte(5, mk_pte(1, 0, 1, 1, 9'h1A3));
        set_pte(6, mk_pte(1, 0, 0, 1, 9'h044));
        set_pte(7, mk_pte(0, 0, 1, 1, 9'h011));
        set_pte(8, mk_pte(1, 0, 1, 1, 9'h022) | 32'h0000_0400);
        set_pte(4096 + 5, mk_pte(1, 0, 1, 1, 9'h0F0));
        for (int v = 100; v < 140; v++) set_pte(v, mk_pte(1, 0, 1, 1, 9'(v)));
        model_flush();

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
        check(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);

        xlate(12'd5, 0);   // R3 miss
        xlate(12'd5, 0);   // R2 hit
        xlate(12'd5, 1);   // R6 dirty on write hit
        xlate(12'd6, 1);   // R5 miss, read-only page
        xlate(12'd6, 1);   // R5 hit, unchanged
        xlate(12'd6, 0);   // R5 read allowed
        xlate(12'd7, 0);   // R4 invalid
        xlate(12'd7, 0);   // R4 still a miss
        xlate(12'd8, 0);   // R4 reserved bit set
        do_flush();        // R8
        xlate(12'd5, 0);   // R8 miss after flush
        do_flush();
        for (int v = 100; v < 132; v++) xlate(12'(v), 1);   // R7 fill all slots
        xlate(12'd100, 0); // R7 hit refreshes 100
        xlate(12'd132, 0); // R7 evicts 101 (dirty), R6
        xlate(12'd101, 1); // R7 evicts 102
        set_base(4096);    // R8 base change
        xlate(12'd5, 0);   // R3 new table
        set_base(0);

        for (int k = 0; k < 1500; k++) begin
            int r = int'($urandom % 200);
            if (r == 0) do_flush();
            else if (r == 1) set_base(cur_base == 0 ? 4096 : 0);
            xlate(12'(200 + $urandom % 48), 1'($urandom % 2));
        end

        repeat (3) @(negedge clk);
        begin
            int mism = 0;
            for (int i = 0; i < 8192; i++) if (pt_mem[i] !== exp_pt[i]) mism++;
            check(mism == 0, "R6", "page table image after write-backs", mism, 0);
        end
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule